// File: doc/BRIEF.md
# Three-Channel Timer Count Latch and Status Read Path

This block is the host-facing read side of a three-channel interval timer. A byte-wide host bus writes control bytes to a control port and count bytes to one data port per channel. It reads back count and status through the same data ports. Each channel holds a 16-bit count register and a simple down-counting element. The element reloads itself at terminal count, and its OUT level and null-count flag give the status byte real sources.

A control byte either programs a channel's byte-access mode, or freezes a snapshot. There are two snapshot forms. The first is a latch command for a single channel. The second is a read-back command that can snapshot count, status, or both, on any set of channels. A snapshot stays frozen until the host has fully read it, and a further snapshot request for the same item is dropped meanwhile. When both status and count are frozen, the status byte is read first.

Top module: `timer_rd_top`

## Requirements
- R1: After reset every OUT is 1, every channel uses low-then-high byte access with mode bits 0000, and its null-count flag is 1, so a status read-back returns 0xF0.
- R2: Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 is the control port, and a read with address 3 returns 0x00.
- R3: Count writes follow the channel's access code: 01 loads the low byte with the high byte zero, 10 loads the high byte with the low byte zero, and 11 takes low then high through a write toggle. A control write to the channel resets that toggle.
- R4: The null-count flag (status bit 6) is set by every count byte write and every mode write. It clears on the clock edge after the final count byte, where the count register is copied into the counting element.
- R5: Once loaded, each cycle with the channel's tick high changes the element. When it holds 1, it reloads from the count register; otherwise it decrements, and 0 wraps to 0xFFFF. OUT goes to 0 for the tick that brings the element to 1 and returns to 1 on the reload.
- R6: A control byte with bits 7:6 = 00/01/10 (channel 0/1/2) and bits 5:4 = 00 latches that channel's count as it stood in the write cycle. The latch holds until it has been read in the channel's byte order, and a repeat latch command before then is ignored.
- R7: A control byte with bits 7:6 = 11 is a read-back command. Bits 3:1 mask channels 0..2 (bit 1 = channel 0). Bit 5 = 0 latches the count, and bit 4 = 0 latches the status. An item that is already latched is not overwritten.
- R8: The status byte is {OUT, null-count, access code[1:0], mode bits[3:0]} from bit 7 down. When it is latched, the next data read of that channel returns it, and the count bytes follow.
- R9: With nothing latched, a data read returns the live element in the access order (01 low byte, 10 high byte, 11 low then high through a read toggle).
- R10: A control byte with bits 7:6 selecting a channel and bits 5:4 non-zero stores bits 5:4 as the access code and bits 3:0 as the mode bits. It drops that channel's latches, stops its counting until a new count is loaded, sets its OUT to 1 and sets its null-count flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe; ignored in a cycle with wr_en_i |
| addr_i | input | 2 | Port select: 0..2 data ports, 3 control |
| wdata_i | input | 8 | Host write byte |
| tick_i | input | 3 | Per-channel count enable |
| rdata_o | output | 8 | Read byte for the addressed port, valid in the cycle of the read |
| out_o | output | 3 | Per-channel OUT level |

## Verification
The null-count flag is only visible as 1 in a single cycle: the one between the final count byte and the transfer into the counting element. The bench gets there by issuing a status read-back in the cycle right after the last count byte and expecting bit 6 set, then repeating the read-back later and expecting it clear. Rejection of a second snapshot is shown by making the live value drift with ticks between two latch requests, so that a wrongly refreshed latch would return a different byte. Random loads with random access codes, tick counts and latch forms then compare the latched bytes with a bench-side count model.

// File: rtl/timer_rd_pkg.sv
package timer_rd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;
  localparam int unsigned MODE_W = 4;

  typedef enum logic [1:0] {
    RW_LATCH = 2'b00,
    RW_LO    = 2'b01,
    RW_HI    = 2'b10,
    RW_LOHI  = 2'b11
  } rw_e;

  typedef struct packed {
    logic              out;
    logic              null_cnt;
    rw_e               rw;
    logic [MODE_W-1:0] mode;
  } status_t;
endpackage

// File: rtl/timer_ctrl_dec.sv
module timer_ctrl_dec #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              wr_i,
  input  logic [7:0]        byte_i,
  output logic [NUM_CH-1:0] mode_wr_o,
  output logic [NUM_CH-1:0] latch_cnt_o,
  output logic [NUM_CH-1:0] latch_st_o
);
  logic readback;
  assign readback = (byte_i[7:6] == 2'b11);

  always_comb begin
    mode_wr_o   = '0;
    latch_cnt_o = '0;
    latch_st_o  = '0;
    if (wr_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (readback) begin
          // mask bit c+1 selects channel c; active-low latch requests
          latch_cnt_o[c] = byte_i[c+1] & ~byte_i[5];
          latch_st_o[c]  = byte_i[c+1] & ~byte_i[4];
        end else if (32'(byte_i[7:6]) == c) begin
          if (byte_i[5:4] == 2'b00) latch_cnt_o[c] = 1'b1;
          else                      mode_wr_o[c]   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/timer_cnt_elem.sv
module timer_cnt_elem
  import timer_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              mode_wr_i,
  input  logic [5:0]        mode_i,
  output logic [CNT_W-1:0]  ce_o,
  output logic              out_o,
  output logic              null_o,
  output logic              pend_o,
  output rw_e               rw_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [CNT_W-1:0]  cr_q, ce_q;
  logic              armed_q, pend_q, null_q, out_q, wtog_q;
  rw_e               rw_q;
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_q    <= '0;
      ce_q    <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      null_q  <= 1'b1;
      out_q   <= 1'b1;
      wtog_q  <= 1'b0;
      rw_q    <= RW_LOHI;
      mode_q  <= '0;
    end else if (mode_wr_i) begin
      rw_q    <= rw_e'(mode_i[5:4]);
      mode_q  <= mode_i[MODE_W-1:0];
      wtog_q  <= 1'b0;
      null_q  <= 1'b1;
      pend_q  <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= 1'b1;
    end else if (wr_i) begin
      null_q <= 1'b1;
      case (rw_q)
        RW_LO: begin
          cr_q   <= {{BYTE_W{1'b0}}, wdata_i};
          pend_q <= 1'b1;
        end
        RW_HI: begin
          cr_q   <= {wdata_i, {BYTE_W{1'b0}}};
          pend_q <= 1'b1;
        end
        default: begin
          if (!wtog_q) begin
            cr_q[BYTE_W-1:0] <= wdata_i;
            wtog_q           <= 1'b1;
            pend_q           <= 1'b0;
          end else begin
            cr_q[CNT_W-1:BYTE_W] <= wdata_i;
            wtog_q               <= 1'b0;
            pend_q               <= 1'b1;
          end
        end
      endcase
    end else if (pend_q) begin
      ce_q    <= cr_q;
      armed_q <= 1'b1;
      pend_q  <= 1'b0;
      null_q  <= 1'b0;
      out_q   <= 1'b1;
    end else if (armed_q && tick_i) begin
      if (ce_q == CNT_W'(1)) begin
        ce_q  <= cr_q;
        out_q <= 1'b1;
      end else begin
        ce_q  <= ce_q - CNT_W'(1);
        out_q <= (ce_q != CNT_W'(2));
      end
    end
  end

  assign ce_o   = ce_q;
  assign out_o  = out_q;
  assign null_o = null_q;
  assign pend_o = pend_q;
  assign rw_o   = rw_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/timer_rd_path.sv
module timer_rd_path
  import timer_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              mode_wr_i,
  input  logic              latch_cnt_i,
  input  logic              latch_st_i,
  input  logic [CNT_W-1:0]  ce_i,
  input  status_t           status_i,
  input  rw_e               rw_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              cnt_lat_o,
  output logic              st_lat_o,
  output logic [CNT_W-1:0]  hold_o
);
  logic [CNT_W-1:0] hold_q, src;
  logic             cnt_lat_q, st_lat_q, rtog_q, hi_sel, last_byte;
  status_t          st_q;

  assign hi_sel    = (rw_i == RW_HI) || (rw_i == RW_LOHI && rtog_q);
  assign last_byte = (rw_i != RW_LOHI) || rtog_q;
  assign src       = cnt_lat_q ? hold_q : ce_i;

  always_comb begin
    if (st_lat_q)    rdata_o = st_q;
    else if (hi_sel) rdata_o = src[CNT_W-1:BYTE_W];
    else             rdata_o = src[BYTE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= '0;
      cnt_lat_q <= 1'b0;
      st_lat_q  <= 1'b0;
      st_q      <= '0;
      rtog_q    <= 1'b0;
    end else if (mode_wr_i) begin
      cnt_lat_q <= 1'b0;
      st_lat_q  <= 1'b0;
      rtog_q    <= 1'b0;
    end else begin
      if (latch_st_i && !st_lat_q) begin
        st_q     <= status_i;
        st_lat_q <= 1'b1;
      end
      if (latch_cnt_i && !cnt_lat_q) begin
        hold_q    <= ce_i;
        cnt_lat_q <= 1'b1;
      end
      if (rd_i) begin
        if (st_lat_q) begin
          st_lat_q <= 1'b0;
        end else begin
          if (rw_i == RW_LOHI) rtog_q <= ~rtog_q;
          if (cnt_lat_q && last_byte) cnt_lat_q <= 1'b0;
        end
      end
    end
  end

  assign cnt_lat_o = cnt_lat_q;
  assign st_lat_o  = st_lat_q;
  assign hold_o    = hold_q;
endmodule

// File: rtl/timer_rd_top.sv
module timer_rd_top
  import timer_rd_pkg::*;
#(
  parameter  int unsigned NUM_CH = 3,
  localparam int unsigned AW     = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] tick_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] out_o
);
  logic                           wr_ctrl;
  logic [NUM_CH-1:0]              mode_wr, latch_cnt, latch_st;
  logic [NUM_CH-1:0]              null_w, pend_w, cnt_lat_w, st_lat_w;
  logic [NUM_CH-1:0][CNT_W-1:0]   hold_w;
  logic [NUM_CH-1:0][BYTE_W-1:0]  byte_w;

  assign wr_ctrl = wr_en_i && (addr_i == AW'(NUM_CH));

  timer_ctrl_dec #(.NUM_CH(NUM_CH)) u_dec (
    .wr_i        (wr_ctrl),
    .byte_i      (wdata_i),
    .mode_wr_o   (mode_wr),
    .latch_cnt_o (latch_cnt),
    .latch_st_o  (latch_st)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              wr_c, rd_c;
    logic [CNT_W-1:0]  ce_c;
    rw_e               rw_c;
    logic [MODE_W-1:0] mode_c;
    status_t           st_c;

    assign wr_c = wr_en_i && (addr_i == AW'(c));
    assign rd_c = rd_en_i && !wr_en_i && (addr_i == AW'(c));
    assign st_c = {out_o[c], null_w[c], rw_c, mode_c};

    timer_cnt_elem u_elem (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i[c]),
      .wr_i      (wr_c),
      .wdata_i   (wdata_i),
      .mode_wr_i (mode_wr[c]),
      .mode_i    (wdata_i[5:0]),
      .ce_o      (ce_c),
      .out_o     (out_o[c]),
      .null_o    (null_w[c]),
      .pend_o    (pend_w[c]),
      .rw_o      (rw_c),
      .mode_o    (mode_c)
    );

    timer_rd_path u_rd (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rd_i        (rd_c),
      .mode_wr_i   (mode_wr[c]),
      .latch_cnt_i (latch_cnt[c]),
      .latch_st_i  (latch_st[c]),
      .ce_i        (ce_c),
      .status_i    (st_c),
      .rw_i        (rw_c),
      .rdata_o     (byte_w[c]),
      .cnt_lat_o   (cnt_lat_w[c]),
      .st_lat_o    (st_lat_w[c]),
      .hold_o      (hold_w[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == AW'(c)) rdata_o = byte_w[c];
    end
  end
endmodule

// File: rtl/timer_rd_chk.sv
module timer_rd_chk
  import timer_rd_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned AW     = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wr_en_i,
  input logic                         rd_en_i,
  input logic [AW-1:0]                addr_i,
  input logic [7:1]                   wbits_i,
  input logic [NUM_CH-1:0]            tick_i,
  input logic [NUM_CH-1:0]            out_i,
  input logic [BYTE_W-1:0]            rdata_i,
  input logic [NUM_CH-1:0]            null_i,
  input logic [NUM_CH-1:0]            pend_i,
  input logic [NUM_CH-1:0]            cnt_lat_i,
  input logic [NUM_CH-1:0]            st_lat_i,
  input logic [NUM_CH-1:0][CNT_W-1:0] hold_i
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (addr_i == AW'(NUM_CH));

  p_ctrl_rd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(NUM_CH)) |-> (rdata_i == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    p_null_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == AW'(c)) |=> null_i[c]);

    p_null_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_i[c] && !wr_en_i) |=> !null_i[c]);

    p_out_short_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!out_i[c] && tick_i[c] && !wr_en_i) |=> out_i[c]);

    p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_lat_i[c] && !wr_en_i && !rd_en_i) |=> (cnt_lat_i[c] && $stable(hold_i[c])));

    p_relatch_ign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_lat_i[c] && ctrl_wr && 32'(wbits_i[7:6]) == c && wbits_i[5:4] == 2'b00)
      |=> $stable(hold_i[c]));

    p_rb_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr && wbits_i[7:6] == 2'b11 && wbits_i[c+1] && !wbits_i[4]) |=> st_lat_i[c]);

    p_status_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_lat_i[c] && rd_en_i && !wr_en_i && addr_i == AW'(c))
      |=> (!st_lat_i[c] && cnt_lat_i[c] == $past(cnt_lat_i[c])));

    p_mode_null_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr && 32'(wbits_i[7:6]) == c && wbits_i[5:4] != 2'b00)
      |=> (null_i[c] && out_i[c] && !cnt_lat_i[c] && !st_lat_i[c]));
  end
endmodule

bind timer_rd_top timer_rd_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .wbits_i   (wdata_i[7:1]),
  .tick_i    (tick_i),
  .out_i     (out_o),
  .rdata_i   (rdata_o),
  .null_i    (null_w),
  .pend_i    (pend_w),
  .cnt_lat_i (cnt_lat_w),
  .st_lat_i  (st_lat_w),
  .hold_i    (hold_w)
);

// File: tb/tb_timer_rd_top.sv
`timescale 1ns/1ps
module tb_timer_rd_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [2:0] tick_i = 3'b000;
  logic [7:0] rdata_o;
  logic [2:0] out_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  timer_rd_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .tick_i(tick_i),
    .rdata_o(rdata_o), .out_o(out_o)
  );

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    bus_rd(a, d);
    chk({8'h00, d}, {8'h00, exp}, tag);
  endtask

  task automatic tick(input int ch, input int n);
    if (n > 0) begin
      tick_i[ch] = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i[ch] = 1'b0;
    end
  endtask

  task automatic load(input int ch, input logic [1:0] rw, input logic [15:0] v, input logic [3:0] md);
    bus_wr(2'd3, {ch[1:0], rw, md});
    case (rw)
      2'b01: bus_wr(ch[1:0], v[7:0]);
      2'b10: bus_wr(ch[1:0], v[15:8]);
      default: begin bus_wr(ch[1:0], v[7:0]); bus_wr(ch[1:0], v[15:8]); end
    endcase
    idle(1);
  endtask

  // R5 count model: reload at 1, else decrement with wrap
  function automatic logic [15:0] exp_cnt(input logic [15:0] n, input int k);
    logic [15:0] v = n;
    for (int i = 0; i < k; i++) v = (v == 16'd1) ? n : v - 16'd1;
    return v;
  endfunction

  function automatic logic [15:0] eff_cnt(input logic [1:0] rw, input logic [15:0] v);
    case (rw)
      2'b01:   return {8'h00, v[7:0]};
      2'b10:   return {v[15:8], 8'h00};
      default: return v;
    endcase
  endfunction

  task automatic rd_count(input int ch, input logic [1:0] rw, input logic [15:0] exp, input string tag);
    case (rw)
      2'b01: rd_chk(ch[1:0], exp[7:0], tag);
      2'b10: rd_chk(ch[1:0], exp[15:8], tag);
      default: begin rd_chk(ch[1:0], exp[7:0], tag); rd_chk(ch[1:0], exp[15:8], tag); end
    endcase
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4471));
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // reset state
    chk({13'd0, out_o}, 16'h0007, "R1 out after reset");
    rd_chk(2'd3, 8'h00, "R2 control port read");
    bus_wr(2'd3, 8'hEE);
    rd_chk(2'd0, 8'hF0, "R1 R8 status ch0 reset");
    rd_chk(2'd1, 8'hF0, "R1 status ch1 reset");
    rd_chk(2'd2, 8'hF0, "R1 status ch2 reset");

    // lo/hi load, live read, mode echo
    load(0, 2'b11, 16'h1234, 4'h4);
    rd_chk(2'd0, 8'h34, "R9 R3 live low");
    rd_chk(2'd0, 8'h12, "R9 R3 live high");
    bus_wr(2'd3, 8'hE2);
    rd_chk(2'd0, 8'hB4, "R8 status mode echo");

    // null-count window
    bus_wr(2'd3, 8'h70);
    bus_wr(2'd1, 8'hCD);
    bus_wr(2'd1, 8'hAB);
    bus_wr(2'd3, 8'hE4);
    rd_chk(2'd1, 8'hF0, "R4 null set before transfer");
    bus_wr(2'd3, 8'hE4);
    rd_chk(2'd1, 8'hB0, "R4 null cleared after transfer");
    rd_chk(2'd1, 8'hCD, "R9 ch1 low");
    rd_chk(2'd1, 8'hAB, "R9 ch1 high");

    // OUT pulse, count 3 low-byte mode
    load(2, 2'b01, 16'h0003, 4'h0);
    tick(2, 1);
    chk({15'd0, out_o[2]}, 16'd1, "R5 out high at 2");
    tick(2, 1);
    chk({15'd0, out_o[2]}, 16'd0, "R5 out low at 1");
    tick(2, 1);
    chk({15'd0, out_o[2]}, 16'd1, "R5 out high after reload");
    rd_chk(2'd2, 8'h03, "R5 reloaded value");

    // latch hold and ignored relatch
    load(0, 2'b11, 16'h0110, 4'h0);
    bus_wr(2'd3, 8'h00);
    tick(0, 32);
    rd_chk(2'd0, 8'h10, "R6 latched low");
    bus_wr(2'd3, 8'h00);
    rd_chk(2'd0, 8'h01, "R6 relatch ignored");
    bus_wr(2'd3, 8'h00);
    rd_chk(2'd0, 8'hF0, "R6 new latch low");
    rd_chk(2'd0, 8'h00, "R6 new latch high");

    // status then count, ch2 (element 3, OUT 1)
    bus_wr(2'd3, 8'hC8);
    rd_chk(2'd2, 8'h90, "R8 status first");
    rd_chk(2'd2, 8'h03, "R7 count after status");
    tick(2, 1);
    rd_chk(2'd2, 8'h02, "R9 live after latch freed");
    bus_wr(2'd3, 8'hE8);
    tick(2, 1);
    chk({15'd0, out_o[2]}, 16'd0, "R5 out low");
    bus_wr(2'd3, 8'hE8);
    rd_chk(2'd2, 8'h90, "R7 held status not overwritten");
    rd_chk(2'd2, 8'h01, "R9 live after status");

    // multi-channel count read-back
    bus_wr(2'd3, 8'hD6);
    tick(0, 10);
    tick(1, 10);
    rd_chk(2'd0, 8'hF0, "R7 ch0 latched low");
    rd_chk(2'd0, 8'h00, "R7 ch0 latched high");
    rd_chk(2'd1, 8'hCD, "R7 ch1 latched low");
    rd_chk(2'd1, 8'hAB, "R7 ch1 latched high");
    rd_chk(2'd0, 8'hE6, "R9 ch0 live low");
    rd_chk(2'd0, 8'h00, "R9 ch0 live high");
    rd_chk(2'd1, 8'hC3, "R9 ch1 live low");
    rd_chk(2'd1, 8'hAB, "R9 ch1 live high");

    // mode write drops latch and stops counting
    bus_wr(2'd3, 8'h00);
    tick(0, 3);
    bus_wr(2'd3, 8'h10);
    rd_chk(2'd0, 8'hE3, "R10 latch dropped");
    tick(0, 2);
    rd_chk(2'd0, 8'hE3, "R10 counting stopped");
    bus_wr(2'd3, 8'hE2);
    rd_chk(2'd0, 8'hD0, "R10 status after mode write");

    // write toggle reset by control write
    bus_wr(2'd3, 8'h70);
    bus_wr(2'd1, 8'h55);
    bus_wr(2'd3, 8'h70);
    bus_wr(2'd1, 8'h22);
    bus_wr(2'd1, 8'h11);
    idle(1);
    rd_chk(2'd1, 8'h22, "R3 toggle reset low");
    rd_chk(2'd1, 8'h11, "R3 toggle reset high");

    // random loads and latches
    for (int it = 0; it < 40; it++) begin
      int ch = int'($urandom % 3);
      logic [1:0] rw = 2'(1 + $urandom % 3);
      logic [15:0] n = 16'(16'h0200 + $urandom % 16'hFD00);
      int k = int'($urandom % 200);
      logic [15:0] e;
      load(ch, rw, n, 4'h0);
      tick(ch, k);
      e = exp_cnt(eff_cnt(rw, n), k);
      if ($urandom % 2 == 0) bus_wr(2'd3, {ch[1:0], 6'b000000});
      else                   bus_wr(2'd3, 8'hD0 | 8'(1 << (ch + 1)));
      tick(ch, int'($urandom % 20));
      rd_count(ch, rw, e, "R6 R7 random latched count");
      bus_wr(2'd3, 8'hE0 | 8'(1 << (ch + 1)));
      rd_chk(ch[1:0], {out_o[ch], 1'b0, rw, 4'h0}, "R8 random status");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule